// File: doc/BRIEF.md
# Dual-Motor Complementary PWM Generator

This block drives the two half-bridge pairs of a twin DC-motor drive from a single free-running PWM timebase. Each motor receives a signed speed command. The command is clamped to a full-scale magnitude of one and then mapped onto a compare value that sits around the midpoint of the PWM period. A command of zero therefore gives 50 % duty, and the motor sees no net voltage. Each motor owns two output legs. Both legs use the same compare value, but one leg is active-high and the other is the exact inverse, so the two legs always drive opposite polarity.

The period of the timebase comes from a runtime input and is counted in prescaled ticks. The system clock is divided by `2 << PRESCALE_LOG2` to form one tick. After reset, the period is derived from the `SYS_CLK_HZ` and `PWM_HZ` parameters. Compare values and the period are only taken up when the counter wraps, so a command that changes mid-period never cuts a pulse short. An enable input forces every leg low at once.

Speed commands are `SPD_W`-bit two's complement numbers. Full scale is `FS = 2**(SPD_W-2)` (1024 by default), which stands for a speed of +1.0.

Top module: `hbridge_pwm`

## Requirements
- R1: While reset is asserted all four outputs are 0. After reset the period is `SYS_CLK_HZ / (2 << PRESCALE_LOG2) / PWM_HZ` ticks (6000 by default), and both motors run at exactly 50 % duty until the first wrap.
- R2: For a command s with |s| <= FS and a period P, the compare value is C = floor(P*(s+FS)/(2*FS)). The active-high leg of that motor is high for C*DIV out of every P*DIV clocks, where DIV = 2 << PRESCALE_LOG2 (2 by default). s = +FS gives a leg that is always high, and s = -FS gives one that is always low.
- R3: A command above +FS acts exactly like +FS, and a command below -FS acts exactly like -FS.
- R4: While enabled, the second leg of each pair is the logical inverse of the first leg in every clock cycle, so it is high for (P-C)*DIV clocks per period.
- R5: Channel mapping: `pwm_o[0]` (active-high) and `pwm_o[1]` (inverted) follow `speed_b_i`. `pwm_o[2]` (active-high) and `pwm_o[3]` (inverted) follow `speed_a_i`.
- R6: A change of a speed command is only applied at the next counter wrap. The pulse already in progress keeps its old width.
- R7: The period is taken from `period_i` at each wrap, and values below 2 are treated as 2. The counter steps once every DIV clocks through 0..P-1. An active-high leg is high while the count is below C.
- R8: When `en_i` is 0, all four outputs are 0 in the same cycle. The timebase keeps running, and the outputs resume when `en_i` returns to 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| en_i | input | 1 | Output enable; 0 forces all legs low |
| speed_a_i | input | SPD_W | Signed speed command for motor A |
| speed_b_i | input | SPD_W | Signed speed command for motor B |
| period_i | input | CNT_W | PWM period in ticks, latched at wrap |
| pwm_o | output | 4 | Leg outputs, mapped per R5 |

## Verification
The bench goes after the extremes of the duty mapping. A command at exactly plus or minus full scale must give a leg that is stuck high or stuck low. Commands just past full scale, and at the most negative code, must clamp to those same stuck levels; a missing or sign-confused clamp shows up as wrapped or garbage duty. The one-count resolution at a large period catches a shift or rounding that is off by one bit.

A speed change is injected right after a rising edge to show that the current pulse keeps its old width. A design that loads compare values immediately would produce a truncated or stretched pulse.

Other tests check that a period request of 1 is floored to 2, and that swapping the motor inputs is caught through distinct per-motor duties. Per-sample checks confirm the inverted legs never equal their partners and that disabling drops every leg in the same cycle.

// File: rtl/hbp_pkg.sv
`timescale 1ns/1ps
package hbp_pkg;

  // Polarity of one output leg relative to the compare match
  typedef enum logic {
    POL_HIGH = 1'b0,
    POL_LOW  = 1'b1
  } leg_pol_e;

  localparam int unsigned LEGS_PER_MOTOR = 2;
  localparam int unsigned NUM_MOTORS     = 2;
  localparam int unsigned NUM_LEGS       = LEGS_PER_MOTOR * NUM_MOTORS;

  // Motor slot for a leg: slot 0 = motor B, slot 1 = motor A
  function automatic int unsigned leg_motor(input int unsigned leg);
    return leg / LEGS_PER_MOTOR;
  endfunction

  // Even legs are active-high, odd legs are the inverted partner
  function automatic leg_pol_e leg_pol(input int unsigned leg);
    return ((leg % LEGS_PER_MOTOR) == 1) ? POL_LOW : POL_HIGH;
  endfunction

endpackage

// File: rtl/hbp_rst_sync.sv
`timescale 1ns/1ps
module hbp_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_s_n
);
  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb sync_d = {sync_q[0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= sync_d;
  end

  assign rst_s_n = sync_q[1];
endmodule

// File: rtl/hbp_prescaler.sv
`timescale 1ns/1ps
module hbp_prescaler #(
  parameter int unsigned PRESCALE_LOG2 = 0
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick_o
);
  localparam int unsigned PS_W = PRESCALE_LOG2 + 1;

  logic [PS_W-1:0] ps_q;
  logic [PS_W-1:0] ps_d;

  always_comb ps_d = ps_q + PS_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ps_q <= '0;
    else        ps_q <= ps_d;
  end

  assign tick_o = &ps_q;
endmodule

// File: rtl/hbp_counter.sv
`timescale 1ns/1ps
module hbp_counter #(
  parameter int unsigned          CNT_W      = 16,
  parameter logic [CNT_W-1:0]     DEF_PERIOD = 16'd6000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] per_load_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] per_o,
  output logic             wrap_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] per_q, per_d;
  logic             last;

  always_comb begin
    last   = (cnt_q == (per_q - CNT_W'(1)));
    wrap_o = tick_i & last;
    cnt_d  = cnt_q;
    per_d  = per_q;
    if (tick_i) begin
      cnt_d = last ? '0 : (cnt_q + CNT_W'(1));
    end
    if (wrap_o) begin
      per_d = per_load_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      per_q <= DEF_PERIOD;
    end else begin
      cnt_q <= cnt_d;
      per_q <= per_d;
    end
  end

  assign cnt_o = cnt_q;
  assign per_o = per_q;
endmodule

// File: rtl/hbp_duty_map.sv
`timescale 1ns/1ps
module hbp_duty_map #(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned SPD_W = 12
) (
  input  logic signed [SPD_W-1:0] speed_i,
  input  logic        [CNT_W-1:0] period_i,
  output logic        [CNT_W-1:0] cmp_o
);
  localparam int unsigned FS_LOG2 = SPD_W - 2;
  localparam int unsigned PROD_W  = CNT_W + SPD_W;
  localparam logic signed [SPD_W:0] FS_P = (SPD_W+1)'(1 << FS_LOG2);
  localparam logic signed [SPD_W:0] FS_N = -FS_P;

  logic signed [SPD_W:0] ext;
  logic signed [SPD_W:0] clamped;
  logic signed [SPD_W:0] shifted;
  logic        [SPD_W-1:0] offs;
  logic        [PROD_W-1:0] prod;

  always_comb begin
    ext = {speed_i[SPD_W-1], speed_i};
    if (ext > FS_P)      clamped = FS_P;
    else if (ext < FS_N) clamped = FS_N;
    else                 clamped = ext;
    // Shift into 0..2*FS, which fits SPD_W unsigned bits
    shifted = clamped + FS_P;
    offs    = shifted[SPD_W-1:0];
    prod    = {{SPD_W{1'b0}}, period_i} * {{CNT_W{1'b0}}, offs};
    cmp_o   = prod[PROD_W-2 -: CNT_W];
  end
endmodule

// File: rtl/hbridge_pwm.sv
`timescale 1ns/1ps
module hbridge_pwm #(
  parameter int unsigned SYS_CLK_HZ    = 48_000_000,
  parameter int unsigned PWM_HZ        = 4_000,
  parameter int unsigned PRESCALE_LOG2 = 0,
  parameter int unsigned CNT_W         = 16,
  parameter int unsigned SPD_W         = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic [SPD_W-1:0] speed_a_i,
  input  logic [SPD_W-1:0] speed_b_i,
  input  logic [CNT_W-1:0] period_i,
  output logic [3:0]       pwm_o
);
  import hbp_pkg::*;

  localparam int unsigned TICK_HZ    = SYS_CLK_HZ / (2 << PRESCALE_LOG2);
  localparam int unsigned DEF_PER_I  = TICK_HZ / PWM_HZ;
  localparam logic [CNT_W-1:0] DEF_PERIOD = CNT_W'(DEF_PER_I);
  localparam logic [CNT_W-1:0] CMP_RST    = CNT_W'(DEF_PER_I / 2);
  localparam logic [CNT_W-1:0] MIN_PERIOD = CNT_W'(2);

  logic             rst_s_n;
  logic             tick_w;
  logic             wrap_w;
  logic [CNT_W-1:0] cnt_w;
  logic [CNT_W-1:0] per_w;
  logic [CNT_W-1:0] per_load;
  logic             gate;
  logic [SPD_W-1:0] spd_arr [NUM_MOTORS];
  logic [CNT_W-1:0] cmp_q   [NUM_MOTORS];

  hbp_rst_sync u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_s_n (rst_s_n)
  );

  hbp_prescaler #(.PRESCALE_LOG2(PRESCALE_LOG2)) u_ps (
    .clk    (clk),
    .rst_n  (rst_s_n),
    .tick_o (tick_w)
  );

  assign per_load = (period_i < MIN_PERIOD) ? MIN_PERIOD : period_i;

  hbp_counter #(.CNT_W(CNT_W), .DEF_PERIOD(DEF_PERIOD)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_s_n),
    .tick_i     (tick_w),
    .per_load_i (per_load),
    .cnt_o      (cnt_w),
    .per_o      (per_w),
    .wrap_o     (wrap_w)
  );

  // Slot 0 = motor B, slot 1 = motor A
  assign spd_arr[0] = speed_b_i;
  assign spd_arr[1] = speed_a_i;

  for (genvar m = 0; m < NUM_MOTORS; m++) begin : g_mot
    logic [CNT_W-1:0] map_c;
    logic [CNT_W-1:0] cmp_d;
    logic [CNT_W-1:0] cmp_r;

    hbp_duty_map #(.CNT_W(CNT_W), .SPD_W(SPD_W)) u_map (
      .speed_i  (spd_arr[m]),
      .period_i (per_load),
      .cmp_o    (map_c)
    );

    always_comb cmp_d = wrap_w ? map_c : cmp_r;

    always_ff @(posedge clk or negedge rst_s_n) begin
      if (!rst_s_n) cmp_r <= CMP_RST;
      else          cmp_r <= cmp_d;
    end

    assign cmp_q[m] = cmp_r;
  end

  assign gate = rst_s_n & en_i;

  for (genvar l = 0; l < NUM_LEGS; l++) begin : g_leg
    localparam int unsigned MI  = leg_motor(l);
    localparam leg_pol_e    POL = leg_pol(l);
    logic raw;
    assign raw = (cnt_w < cmp_q[MI]);
    if (POL == POL_LOW) begin : g_inv
      assign pwm_o[l] = gate & ~raw;
    end else begin : g_dir
      assign pwm_o[l] = gate & raw;
    end
  end
endmodule

// File: rtl/hbp_checker.sv
`timescale 1ns/1ps
module hbp_checker #(
  parameter int unsigned CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en_i,
  input logic [3:0]       pwm_o,
  input logic             tick,
  input logic             wrap,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] per,
  input logic [CNT_W-1:0] cmp_b,
  input logic [CNT_W-1:0] cmp_a
);
  p_legs_inverse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    en_i |-> ((pwm_o[0] != pwm_o[1]) && (pwm_o[2] != pwm_o[3])));

  p_off_when_disabled_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |-> (pwm_o == 4'b0000));

  p_hold_between_wraps_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !wrap |=> ($stable(cmp_a) && $stable(cmp_b) && $stable(per)));

  p_cmp_within_period_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_a <= per) && (cmp_b <= per));

  p_cnt_below_period_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cnt < per);

  p_period_floor_r7: assert property (@(posedge clk) disable iff (!rst_n)
    per >= CNT_W'(2));

  p_tick_spacing_r7: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);

  p_count_steps_on_tick_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(cnt));
endmodule

bind hbridge_pwm hbp_checker #(.CNT_W(CNT_W)) u_chk (
  .clk   (clk),
  .rst_n (rst_s_n),
  .en_i  (en_i),
  .pwm_o (pwm_o),
  .tick  (tick_w),
  .wrap  (wrap_w),
  .cnt   (cnt_w),
  .per   (per_w),
  .cmp_b (cmp_q[0]),
  .cmp_a (cmp_q[1])
);

// File: tb/tb_hbridge_pwm.sv
`timescale 1ns/1ps
module tb_hbridge_pwm;
  localparam int CNT_W = 16;
  localparam int SPD_W = 12;
  localparam int FS    = 1024;
  localparam int DIV   = 2;
  localparam int DEF_P = 6000;

  logic                    clk;
  logic                    rst_n;
  logic                    en_i;
  logic signed [SPD_W-1:0] spd_a;
  logic signed [SPD_W-1:0] spd_b;
  logic [CNT_W-1:0]        period_i;
  logic [3:0]              pwm_o;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;
  int cur_p  = DEF_P;

  hbridge_pwm dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .en_i      (en_i),
    .speed_a_i (spd_a),
    .speed_b_i (spd_b),
    .period_i  (period_i),
    .pwm_o     (pwm_o)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic int exp_cmp(input int p, input int s);
    int c;
    c = s;
    if (c > FS)  c = FS;
    if (c < -FS) c = -FS;
    return (p * (c + FS)) / (2 * FS);
  endfunction

  function automatic int eff_p(input int p);
    return (p < 2) ? 2 : p;
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic apply(input int sa, input int sb, input int p);
    int np;
    np = eff_p(p);
    @(negedge clk);
    spd_a    = SPD_W'(sa);
    spd_b    = SPD_W'(sb);
    period_i = CNT_W'(p);
    repeat (2 * (cur_p + np) * DIV + 4) @(negedge clk);
    cur_p = np;
  endtask

  // Count the highs on each leg over one full PWM period and check them
  task automatic measure(input int sa, input int sb, input string tag);
    int hi [4];
    int bad_b, bad_a, ca, cb, win;
    for (int i = 0; i < 4; i++) hi[i] = 0;
    bad_a = 0; bad_b = 0;
    win = cur_p * DIV;
    for (int k = 0; k < win; k++) begin
      @(negedge clk);
      for (int i = 0; i < 4; i++) hi[i] += int'(pwm_o[i]);
      if (pwm_o[0] == pwm_o[1]) bad_b++;
      if (pwm_o[2] == pwm_o[3]) bad_a++;
    end
    cb = exp_cmp(cur_p, sb);
    ca = exp_cmp(cur_p, sa);
    check(hi[0] == cb * DIV, {tag, " R2 R5 leg0 motorB"}, hi[0], cb * DIV);
    check(hi[1] == (cur_p - cb) * DIV, {tag, " R4 leg1"}, hi[1], (cur_p - cb) * DIV);
    check(hi[2] == ca * DIV, {tag, " R2 R5 leg2 motorA"}, hi[2], ca * DIV);
    check(hi[3] == (cur_p - ca) * DIV, {tag, " R4 leg3"}, hi[3], (cur_p - ca) * DIV);
    check(bad_b == 0 && bad_a == 0, {tag, " R4 complement"}, bad_a + bad_b, 0);
  endtask

  task automatic wait_rise0();
    logic prev;
    @(negedge clk);
    prev = pwm_o[0];
    forever begin
      @(negedge clk);
      if (!prev && pwm_o[0]) break;
      prev = pwm_o[0];
    end
  endtask

  task automatic run_high0(output int n);
    n = 1;
    forever begin
      @(negedge clk);
      if (!pwm_o[0]) break;
      n++;
    end
  endtask

  initial begin
    int seed_dummy;
    int run, zeros;
    seed_dummy = $urandom(32'h5eed_1234);
    rst_n = 1'b0; en_i = 1'b1;
    spd_a = '0; spd_b = '0; period_i = CNT_W'(DEF_P);

    // R1: outputs low in reset
    zeros = 0;
    repeat (6) begin
      @(negedge clk);
      if (pwm_o != 4'b0000) zeros++;
    end
    check(zeros == 0, "R1 outputs low in reset", zeros, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    measure(0, 0, "R1 default 50pct");

    // Directed cases
    apply(0, 0, 40);              measure(0, 0, "R2 zero P40");
    apply(FS, -FS, 40);           measure(FS, -FS, "R2 full scale");
    apply(2047, -2048, 40);       measure(2047, -2048, "R3 clamp extremes");
    apply(FS + 1, -FS - 1, 50);   measure(FS + 1, -FS - 1, "R3 clamp edge");
    apply(512, -256, 100);        measure(512, -256, "R5 distinct motors");
    apply(1, -1, 2048);           measure(1, -1, "R2 fine resolution");
    apply(0, 300, 1);             measure(0, 300, "R7 period floor");
    apply(-700, 900, 3);          measure(-700, 900, "R7 tiny period");

    // R6: change command right after a pulse starts
    apply(0, 0, 100);
    wait_rise0();
    spd_b = SPD_W'(600);
    run_high0(run);
    check(run == exp_cmp(100, 0) * DIV, "R6 pulse keeps old width", run, exp_cmp(100, 0) * DIV);
    wait_rise0();
    run_high0(run);
    check(run == exp_cmp(100, 600) * DIV, "R6 next pulse uses new width", run, exp_cmp(100, 600) * DIV);

    // R8: disable forces outputs low, then recovers
    @(negedge clk);
    en_i = 1'b0;
    #0;
    zeros = 0;
    for (int k = 0; k < 250; k++) begin
      if (pwm_o != 4'b0000) zeros++;
      @(negedge clk);
    end
    check(zeros == 0, "R8 outputs low when disabled", zeros, 0);
    en_i = 1'b1;
    measure(0, 600, "R8 resume after enable");

    // Random mix
    for (int it = 0; it < 12; it++) begin
      int sa, sb, p;
      sa = int'($urandom_range(0, 2300)) - 1150;
      sb = int'($urandom_range(0, 2300)) - 1150;
      p  = int'($urandom_range(4, 150));
      apply(sa, sb, p);
      measure(sa, sb, "R2 random");
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(190000 * 4);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired R1 actual=0 expected=1");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end
endmodule